// File: doc/BRIEF.md
# Serial Ones-Mod-Three and Even-Zeros Detector

This block watches a serial bit stream, one bit per clock whenever the bit-valid strobe is high. It keeps two small trackers. One holds the number of 1s seen since reset, modulo three. The other records whether the number of 0s seen is none, odd, or even and above zero. The detect condition holds when the 1s count is a multiple of three and the 0s count is even and non-zero. For example, (ones, zeros) pairs such as (0,2), (3,2), (3,4) and (6,2) satisfy it.

The joint state is the product of the two trackers, which gives nine states. They are named (ones class, zeros class):

- Ones classes: ONE_R0, ONE_R1, ONE_R2.
- Zeros classes: ZC_NONE, ZC_ODD, ZC_EVEN.

The transitions are as follows:

- **Ones tracker, on a valid 1:** ONE_R0→ONE_R1→ONE_R2→ONE_R0.
- **Zeros tracker, on a valid 0:** ZC_NONE→ZC_ODD, ZC_ODD→ZC_EVEN, ZC_EVEN→ZC_ODD.
- **Invalid cycles:** when the strobe is low, both trackers hold.

The detect state is (ONE_R0, ZC_EVEN). Only two transitions enter it:

- a valid 0 in (ONE_R0, ZC_ODD);
- a valid 1 in (ONE_R2, ZC_EVEN).

No transition leaves it and returns in one step.

Two flags are provided:

- **Combinational flag:** high during the cycle whose valid bit completes the condition.
- **Registered flag:** high during every cycle in which the machine sits in the detect state.

Top module: `bitseq_detect`

## Requirements
- R1: Each valid 1 advances the ones class cyclically R0→R1→R2→R0; a valid 0 leaves it unchanged.
- R2: Each valid 0 moves the zeros class NONE→ODD, ODD→EVEN, EVEN→ODD; a valid 1 leaves it unchanged.
- R3: `hit_mealy` is 1 exactly in a cycle where `bit_valid`=1 and the sampled bit leads into (R0, EVEN): `bit_in`=0 in (R0, ODD) or `bit_in`=1 in (R2, EVEN); otherwise it is 0.
- R4: While `bit_valid`=0, the state holds and `hit_mealy` is 0 whatever `bit_in` is.
- R5: `hit_moore` is a register that is 1 exactly in the cycles in which the state is (R0, EVEN). It rises after the clock edge that samples the completing bit.
- R6: `rst` is synchronous and active high. It returns the state to (R0, NONE) and clears `hit_moore`, and `hit_mealy` is 0 while `rst` is high.
- R7: The (ones, zeros) count pairs (0,2), (3,2), (3,4) and (6,2) reach detect. The reset state (0,0) does not.
- R8: A valid bit of either value in the detect state leaves it, so `hit_moore` falls after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Strobe: `bit_in` is sampled this cycle |
| bit_in | input | 1 | Serial data bit |
| hit_mealy | output | 1 | Combinational flag on the completing bit |
| hit_moore | output | 1 | Registered flag while in the detect state |

## Verification
The embedded properties watch, on every cycle:

- that the trackers hold while the strobe is low;
- that a valid 1 always moves the ones class and never the zeros class;
- that the zeros class never returns to NONE without reset;
- that the two flags never coincide, and the combinational flag is always followed by the registered one;
- that the detect state is left on any valid bit.

Whether the flags fire on exactly the right counts can only be shown by the bench. It compares against an integer count model, using directed count pairs, idle gaps inside the detect state, mid-stream reset, and a long random stream.

// File: rtl/bitseq_detect_pkg.sv
package bitseq_detect_pkg;
    typedef enum logic [1:0] {
        ONE_R0 = 2'd0,
        ONE_R1 = 2'd1,
        ONE_R2 = 2'd2
    } ones_cls_e;

    typedef enum logic [1:0] {
        ZC_NONE = 2'd0,
        ZC_ODD  = 2'd1,
        ZC_EVEN = 2'd2
    } zero_cls_e;
endpackage

// File: rtl/ones_residue_fsm.sv
module ones_residue_fsm
    import bitseq_detect_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adv,
    output ones_cls_e cur,
    output ones_cls_e nxt
);
    // Next-state logic: step the residue on each accepted 1
    always_comb begin
        nxt = cur;
        if (adv) begin
            unique case (cur)
                ONE_R0:  nxt = ONE_R1;
                ONE_R1:  nxt = ONE_R2;
                ONE_R2:  nxt = ONE_R0;
                default: nxt = ONE_R0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= ONE_R0;
        else     cur <= nxt;
    end

    // R1: a residue step always changes the class
    a_r1_ones_step: assert property (@(posedge clk) disable iff (rst)
        adv |=> (cur != $past(cur)));
endmodule

// File: rtl/zero_class_fsm.sv
module zero_class_fsm
    import bitseq_detect_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adv,
    output zero_cls_e cur,
    output zero_cls_e nxt
);
    // Next-state logic: each accepted 0 flips odd/even; first 0 leaves NONE
    always_comb begin
        nxt = cur;
        if (adv) begin
            unique case (cur)
                ZC_NONE: nxt = ZC_ODD;
                ZC_ODD:  nxt = ZC_EVEN;
                ZC_EVEN: nxt = ZC_ODD;
                default: nxt = ZC_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= ZC_NONE;
        else     cur <= nxt;
    end

    // R2: once a zero is seen the class never returns to NONE without reset
    a_r2_no_return_none: assert property (@(posedge clk) disable iff (rst)
        (cur != ZC_NONE) |=> (cur != ZC_NONE));
    // R2: an accepted zero always toggles into ODD or EVEN
    a_r2_zero_step: assert property (@(posedge clk) disable iff (rst)
        adv |=> (cur != $past(cur)) && (cur != ZC_NONE));
endmodule

// File: rtl/bitseq_detect.sv
module bitseq_detect
    import bitseq_detect_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_in,
    output logic hit_mealy,
    output logic hit_moore
);
    ones_cls_e ones_cur, ones_nxt;
    zero_cls_e zero_cur, zero_nxt;
    logic      take_one, take_zero, lands_detect;

    assign take_one  = bit_valid &  bit_in;
    assign take_zero = bit_valid & ~bit_in;

    ones_residue_fsm u_ones (
        .clk (clk),
        .rst (rst),
        .adv (take_one),
        .cur (ones_cur),
        .nxt (ones_nxt)
    );

    zero_class_fsm u_zero (
        .clk (clk),
        .rst (rst),
        .adv (take_zero),
        .cur (zero_cur),
        .nxt (zero_nxt)
    );

    assign lands_detect = (ones_nxt == ONE_R0) && (zero_nxt == ZC_EVEN);

    // Output process: Mealy flag only on an accepted bit, never in reset
    always_comb begin
        hit_mealy = 1'b0;
        if (!rst && bit_valid) hit_mealy = lands_detect;
    end

    // Registered flag tracks the detect state as it is entered
    always_ff @(posedge clk) begin
        if (rst) hit_moore <= 1'b0;
        else     hit_moore <= lands_detect;
    end

    // R6: reset lands in (R0, NONE) with the registered flag clear
    a_r6_reset_state: assert property (@(posedge clk)
        rst |=> (ones_cur == ONE_R0) && (zero_cur == ZC_NONE) && !hit_moore);
    // R4: idle cycles hold both trackers
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> $stable(ones_cur) && $stable(zero_cur));
    // R1: a valid 1 never disturbs the zeros class
    a_r1_one_keeps_zeros: assert property (@(posedge clk) disable iff (rst)
        take_one |=> $stable(zero_cur));
    // R3: entering detect is never from inside detect
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        hit_mealy |-> !hit_moore);
    // R5: combinational hit is followed by the registered flag
    a_r5_moore_follows: assert property (@(posedge clk) disable iff (rst)
        hit_mealy |=> hit_moore);
    // R8: any valid bit in detect leaves it
    a_r8_leave_detect: assert property (@(posedge clk) disable iff (rst)
        (hit_moore && bit_valid) |=> !hit_moore);
endmodule

// File: tb/bitseq_detect_tb_top.sv
`timescale 1ns/1ps
module bitseq_detect_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic hit_mealy, hit_moore;

    int checks = 0;
    int errors = 0;
    int m_ones = 0;   // ones count modulo 3
    int m_zero = 0;   // zeros count, folded to 0 / 1 / 2 (2 = non-zero even)
    bit exp_moore = 1'b0;

    always #5 clk = ~clk;

    bitseq_detect dut_i (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .hit_mealy (hit_mealy),
        .hit_moore (hit_moore)
    );

    function automatic bit is_detect(input int o, input int z);
        return (o == 0) && (z == 2);
    endfunction

    function automatic int next_zero(input int z);
        return (z == 1) ? 2 : 1;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: check registered flag, drive, check Mealy flag, advance model
    task automatic step(input bit r, input bit v, input bit b, input string req);
        int no, nz;
        @(negedge clk);
        chk({req, " R5 moore"}, hit_moore, exp_moore);
        rst = r; bit_valid = v; bit_in = b;
        no = m_ones; nz = m_zero;
        if (v && b)  no = (m_ones + 1) % 3;
        if (v && !b) nz = next_zero(m_zero);
        #1;
        chk({req, " R3 mealy"}, hit_mealy, !r && v && is_detect(no, nz));
        if (r) begin m_ones = 0; m_zero = 0; end
        else begin m_ones = no; m_zero = nz; end
        exp_moore = !r && is_detect(m_ones, m_zero);
    endtask

    task automatic send_pair(input int ones, input int zeros, input bit zeros_first);
        step(1'b1, 1'b0, 1'b0, "R6");
        if (zeros_first) begin
            for (int i = 0; i < zeros; i++) step(1'b0, 1'b1, 1'b0, "R7 R2");
            for (int i = 0; i < ones;  i++) step(1'b0, 1'b1, 1'b1, "R7 R1");
        end else begin
            for (int i = 0; i < ones;  i++) step(1'b0, 1'b1, 1'b1, "R7 R1");
            for (int i = 0; i < zeros; i++) step(1'b0, 1'b1, 1'b0, "R7 R2");
        end
        step(1'b0, 1'b0, 1'b0, "R7");
        chk("R7 pair detect", hit_moore, 1'b1);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        step(1'b1, 1'b0, 1'b0, "R6");
        step(1'b1, 1'b1, 1'b1, "R6 mealy in reset");
        step(1'b0, 1'b0, 1'b0, "R6 reset state");
        chk("R7 reset not detect", hit_moore, 1'b0);

        send_pair(0, 2, 1'b0);
        send_pair(3, 2, 1'b0);
        send_pair(3, 2, 1'b1);   // completes on a 1 from (R2, EVEN)
        send_pair(3, 4, 1'b1);
        send_pair(6, 2, 1'b0);

        // R4: idle with toggling data inside detect keeps the flag
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, i[0], "R4 idle");
        chk("R4 idle hold", hit_moore, 1'b1);
        // R8: a valid 1 leaves detect
        step(1'b0, 1'b1, 1'b1, "R8 leave");
        step(1'b0, 1'b0, 1'b0, "R8 after");
        chk("R8 left detect", hit_moore, 1'b0);

        // mid-stream reset with valid data applied
        step(1'b0, 1'b1, 1'b0, "R2");
        step(1'b1, 1'b1, 1'b0, "R6 mid reset");
        step(1'b0, 1'b1, 1'b0, "R6 after reset");

        for (int i = 0; i < 3000; i++) begin
            bit r, v, b;
            r = ($urandom % 200) == 0;
            v = ($urandom % 4) != 0;
            b = ($urandom % 2) != 0;
            step(r, v, b, "R1 R2 R3 R4 random");
        end
        step(1'b0, 1'b0, 1'b0, "R5 final");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule